// File: doc/BRIEF.md
# Direction-Switched Serial Audio Word FIFO

This block buffers 32-bit audio words between a processor register port and a serial shift engine. The same storage is used in both directions, and a mode input selects the direction. In transmit mode the processor writes words into the FIFO. Whenever the serializer reports that its holding register is empty, the oldest word is handed over with a one-cycle load strobe. In receive mode the serializer presents each finished word with a valid pulse. That word is queued, and the processor reads it from the head of the queue.

Overflow never stalls either side. A processor write to a full transmit queue is thrown away, and so is a received word that arrives when the queue is full. Both events raise a sticky flag that a clear strobe lowers. A change of direction empties the queue. Full, empty and the occupancy count are visible at all times.

Top module: `audio_word_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `level` is 0, `ovfFlag` is 0 and `txLoad` is 0.
- R2: When `rxMode` is 0, a `cpuWrEn` pulse queues `cpuWrData`. In any cycle where `txHoldEmpty` is 1 and the queue is not empty, `txLoad` is 1 and `txWord` carries the oldest queued word. That word leaves the queue at the clock edge. `txLoad` is never 1 when the queue is empty or when `rxMode` is 1.
- R3: When `rxMode` is 0 and `level` is 8, a processor write is discarded. The eight stored words drain afterwards in their original order, and the discarded word never appears.
- R4: When `rxMode` is 1, an `rxWordValid` pulse queues `rxWord`. `cpuRdData` shows the oldest word combinationally, and a `cpuRdEn` pulse removes that word.
- R5: When `rxMode` is 1, `cpuWrEn` has no effect on `level` or on the queued data.
- R6: When `rxMode` is 1 and `level` is 8, an arriving received word is dropped. The stored words stay intact and in their original order.
- R7: A read while the queue is empty leaves `level` at 0 and `empty` at 1. The data returned has no meaning.
- R8: In the cycle after `rxMode` changes value, `level` is 0. During the cycle in which the change is first seen, no word is queued or removed, and `txLoad` is 0.
- R9: When the queue is neither empty nor full, a push and a pop in the same cycle leave `level` unchanged and keep first-in first-out order.
- R10: `ovfFlag` becomes 1 in the cycle after a discarded write or a dropped received word. It stays 1 until an `ovfClr` pulse that does not coincide with a new drop. If a drop and `ovfClr` fall in the same cycle, the flag is 1 afterwards.
- R11: `level` equals the number of queued words and never exceeds 8. `full` is 1 exactly when `level` is 8, and `empty` is 1 exactly when `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxMode | input | 1 | Direction: 1 = receive, 0 = transmit |
| cpuWrEn | input | 1 | Processor write strobe |
| cpuWrData | input | 32 | Processor write word |
| cpuRdEn | input | 1 | Processor read strobe (pops in receive mode) |
| cpuRdData | output | 32 | Head-of-queue word for the processor |
| txHoldEmpty | input | 1 | Serializer holding register is empty |
| txLoad | output | 1 | Holding register load strobe |
| txWord | output | 32 | Word for the holding register |
| rxWordValid | input | 1 | Serializer finished a received word |
| rxWord | input | 32 | Received word |
| ovfClr | input | 1 | Clears the sticky overflow flag |
| full | output | 1 | Queue holds 8 words |
| empty | output | 1 | Queue holds no words |
| level | output | 4 | Number of queued words |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The receive path is driven by a vector table that mixes single pushes, single pops, simultaneous push and pop at low fill levels, and a pop of an empty queue. Each entry carries the expected head word and the expected level, so a swapped order or a lost word shows up in the data, and a wrong count shows up in the level. The transmit path is filled to capacity, given one extra write, and then drained against the holding-register handshake. This separates correct discard behaviour from a design that overwrites or advances the head. Direction switches, writes in receive mode, and drops that coincide with a flag clear are driven as directed cases.

// File: rtl/awf_pkg.sv
package awf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifo_strobe_t;
endpackage

// File: rtl/awf_datapath.sv
module awf_datapath
  import awf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  fifo_strobe_t               ctl,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          headData,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop;

  assign doPush = ctl.push && !ctl.flush;
  assign doPop  = ctl.pop  && !ctl.flush;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign level    = count;
  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R9
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.push && ctl.pop && !ctl.flush) |=> $stable(count));
  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flush |=> (count == '0));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !ctl.pop);
  // R3
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ctl.push);
endmodule

// File: rtl/awf_ctrl.sv
module awf_ctrl
  import awf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rxMode,
  input  logic         cpuWrEn,
  input  logic         cpuRdEn,
  input  logic         txHoldEmpty,
  input  logic         rxWordValid,
  input  logic         ovfClr,
  input  logic         full,
  input  logic         empty,
  output fifo_strobe_t ctl,
  output logic         rxActive,
  output logic         txLoad,
  output logic         ovfFlag
);
  logic modeQ;
  logic modeChange;
  logic dropEvent;
  logic pushReq, popReq;

  assign modeChange = (rxMode != modeQ);
  assign rxActive   = modeQ;

  always_comb begin
    pushReq = modeQ ? rxWordValid : cpuWrEn;
    popReq  = modeQ ? cpuRdEn     : txHoldEmpty;
  end

  always_comb begin
    ctl.flush = modeChange;
    ctl.push  = !modeChange && pushReq && !full;
    ctl.pop   = !modeChange && popReq  && !empty;
  end

  assign dropEvent = !modeChange && pushReq && full;
  assign txLoad    = ctl.pop && !modeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ   <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      modeQ   <= rxMode;
      ovfFlag <= (ovfFlag && !ovfClr) || dropEvent;
    end
  end

  // R2
  txload_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxMode && modeQ) |-> !txLoad);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !ovfClr) |=> ovfFlag);
  // R3
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxMode && !modeQ && cpuWrEn && full) |=> ovfFlag);
  // R6
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxMode && modeQ && rxWordValid && full) |=> ovfFlag);
endmodule

// File: rtl/audio_word_fifo.sv
module audio_word_fifo
  import awf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxMode,
  input  logic                       cpuWrEn,
  input  logic [DATA_W-1:0]          cpuWrData,
  input  logic                       cpuRdEn,
  output logic [DATA_W-1:0]          cpuRdData,
  input  logic                       txHoldEmpty,
  output logic                       txLoad,
  output logic [DATA_W-1:0]          txWord,
  input  logic                       rxWordValid,
  input  logic [DATA_W-1:0]          rxWord,
  input  logic                       ovfClr,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovfFlag
);
  fifo_strobe_t      ctl;
  logic              rxActive;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] headData;

  assign wrData    = rxActive ? rxWord : cpuWrData;
  assign cpuRdData = headData;
  assign txWord    = headData;

  awf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxMode(rxMode),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .txHoldEmpty(txHoldEmpty),
    .rxWordValid(rxWordValid), .ovfClr(ovfClr),
    .full(full), .empty(empty),
    .ctl(ctl), .rxActive(rxActive), .txLoad(txLoad), .ovfFlag(ovfFlag)
  );

  awf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrData(wrData),
    .headData(headData), .level(level), .full(full), .empty(empty)
  );
endmodule

// File: tb/audio_word_fifo_tb.sv
`timescale 1ns/1ps
module audio_word_fifo_tb;
  logic        clk = 0, rst_n = 0;
  logic        rxMode = 0, cpuWrEn = 0, cpuRdEn = 0, txHoldEmpty = 0;
  logic        rxWordValid = 0, ovfClr = 0;
  logic [31:0] cpuWrData = 0, rxWord = 0;
  logic [31:0] cpuRdData, txWord;
  logic        txLoad, full, empty, ovfFlag;
  logic [3:0]  level;
  int checks = 0, fails = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  audio_word_fifo u_dut (.*);

  // op: 0 push, 1 pop, 2 push+pop, 3 pop of empty queue
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  lvl;
  } vec_t;
  localparam vec_t VEC [11] = '{
    '{2'd0, 32'hA0000001, 32'h0, 4'd1},
    '{2'd0, 32'hA0000002, 32'h0, 4'd2},
    '{2'd1, 32'h0, 32'hA0000001, 4'd1},
    '{2'd2, 32'hA0000003, 32'hA0000002, 4'd1},
    '{2'd0, 32'hA0000004, 32'h0, 4'd2},
    '{2'd1, 32'h0, 32'hA0000003, 4'd1},
    '{2'd1, 32'h0, 32'hA0000004, 4'd0},
    '{2'd3, 32'h0, 32'h0, 4'd0},
    '{2'd0, 32'hA0000005, 32'h0, 4'd1},
    '{2'd2, 32'hA0000006, 32'hA0000005, 4'd1},
    '{2'd1, 32'h0, 32'hA0000006, 4'd0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    cpuWrEn = 0; cpuRdEn = 0; txHoldEmpty = 0; rxWordValid = 0; ovfClr = 0;
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 level", level, 0); chk("R1 ovf", ovfFlag, 0);
    chk("R1 txLoad", txLoad, 0);

    // R2/R3: fill transmit queue, then overfill
    for (int i = 0; i < 8; i++) begin
      cpuWrEn = 1; cpuWrData = 32'hC0DE0000 + i; tick();
    end
    quiet();
    chk("R11 full", full, 1); chk("R11 level", level, 8);
    cpuWrEn = 1; cpuWrData = 32'hDEADBEEF; tick(); quiet();
    chk("R3 level after discard", level, 8);
    chk("R10 ovf set tx", ovfFlag, 1);
    ovfClr = 1; tick(); quiet();
    chk("R10 ovf cleared", ovfFlag, 0);
    for (int i = 0; i < 8; i++) begin
      txHoldEmpty = 1; #1;
      chk("R2 txLoad", txLoad, 1);
      chk("R3 tx order", txWord, 32'hC0DE0000 + i);
      tick();
    end
    chk("R11 empty after drain", empty, 1);
    #1 chk("R2 no load when empty", txLoad, 0);
    quiet();

    // R9 push+pop in transmit
    cpuWrEn = 1; cpuWrData = 32'h11; tick();
    cpuWrData = 32'h22; txHoldEmpty = 1; #1;
    chk("R9 tx load", txLoad, 1); chk("R9 tx word", txWord, 32'h11);
    tick(); quiet();
    chk("R9 level kept", level, 1);

    // R8 mode change flush
    rxMode = 1; txHoldEmpty = 1; #1;
    chk("R8 no load on switch", txLoad, 0);
    tick(); quiet();
    chk("R8 level flushed", level, 0); chk("R8 empty", empty, 1);

    // R5 write ignored in receive
    cpuWrEn = 1; cpuWrData = 32'h55; tick(); quiet();
    chk("R5 level", level, 0); chk("R5 ovf", ovfFlag, 0);

    // R4/R7/R9 table walk
    foreach (VEC[k]) begin
      rxWordValid = (VEC[k].op == 0) || (VEC[k].op == 2);
      rxWord = VEC[k].d;
      cpuRdEn = (VEC[k].op != 0);
      #1;
      if (VEC[k].op == 1 || VEC[k].op == 2)
        chk("R4 head data", cpuRdData, VEC[k].e);
      tick(); quiet();
      chk(VEC[k].op == 3 ? "R7 level" : "R4/R9 level", level, VEC[k].lvl);
      if (VEC[k].op == 3) chk("R7 empty", empty, 1);
    end

    // R6 receive overflow, with clear coinciding (R10)
    for (int i = 0; i < 8; i++) begin
      rxWordValid = 1; rxWord = 32'hB0000000 + i; tick();
    end
    quiet();
    chk("R11 rx full", full, 1);
    rxWordValid = 1; rxWord = 32'hBADBAD00; ovfClr = 1; tick(); quiet();
    chk("R6 level", level, 8); chk("R10 set wins", ovfFlag, 1);
    for (int i = 0; i < 8; i++) begin
      cpuRdEn = 1; #1;
      chk("R6 rx order", cpuRdData, 32'hB0000000 + i);
      tick();
    end
    quiet();
    chk("R6 drained", level, 0);
    chk("R10 still sticky", ovfFlag, 1);
    ovfClr = 1; tick(); quiet();
    chk("R10 cleared", ovfFlag, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule